// File: doc/BRIEF.md
# IPv4 Forwarding Header Rewrite Stage

This block performs the per-packet header rewrite of an IPv4 forwarding path. Each cycle it can accept one 20-byte option-free header, given in parallel, together with the result of a destination lookup that ran alongside it: a hit flag and an egress port number. Two cycles later it returns either the rewritten header tagged with its egress port, or the original header marked as dropped with a reason code.

A forwarded header leaves with its time-to-live reduced by one and its checksum repaired in place by a single one's-complement addition, not by summing the ten header words again. Headers that are malformed, that have run out of time-to-live, or whose destination the lookup did not find, are never forwarded and never flooded. Dropped headers still travel through the pipeline, so that a downstream stage can count or discard them.

Input and output both use a valid/ready handshake. All stages move together, so a stalled output holds its result and refuses new input until the stall ends.

Top module: `ipv4_fwd_rewrite`

## Requirements
- R1: A header whose version nibble (bits 159:156) is not 4, or whose length nibble (bits 155:152) is not 5, is dropped with reason code 3 and leaves unchanged. The header is big-endian, with byte 0 in bits 159:152.
- R2: A well-formed header whose TTL byte (bits 95:88) is 0 or 1 is dropped with reason code 2 and leaves unchanged.
- R3: A well-formed header with TTL of at least 2 and a lookup miss is dropped with reason code 1 and leaves unchanged. Every dropped result raises out_drop and drives out_port to 0.
- R4: A well-formed header with TTL of at least 2 and a lookup hit is forwarded with reason code 0 and out_drop low. Its TTL is one lower, out_port equals the looked-up port, and every byte except TTL and checksum is unchanged.
- R5: The checksum of a forwarded header (bits 79:64) becomes the old checksum plus 0x0100, with any carry out of bit 15 added back into bit 0.
- R6: With out_ready held high, in_ready is high, and a header accepted at one clock edge appears with out_valid high after exactly the second following edge.
- R7: While out_valid is high and out_ready is low, the output does not change, in_ready is low, and no accepted header is lost.
- R8: After reset, out_valid is low and in_ready is high.
- R9: When several drop causes apply at once, the malformed cause wins over TTL expiry, and TTL expiry wins over a lookup miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Header and lookup result are present |
| in_ready | output | 1 | Block accepts a header this cycle |
| in_hdr | input | 160 | Option-free IPv4 header, byte 0 in the top bits |
| in_hit | input | 1 | Lookup found the destination address |
| in_port | input | PORT_W | Egress port from the lookup |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_hdr | output | 160 | Rewritten header, or the original when dropped |
| out_port | output | PORT_W | Egress port, 0 when dropped |
| out_drop | output | 1 | Result is to be discarded |
| out_reason | output | 2 | 0 forward, 1 lookup miss, 2 TTL expired, 3 malformed |

## Verification
The assertions assume that the hit flag and port arrive in the same cycle as the header they belong to, and that in_valid stays low while reset is applied. They do not assume that the incoming checksum is correct, because the block only adjusts the checksum and never checks it. The bench builds each header with a correct checksum and takes the hit flag and port from its own small exact-match table, so lookup results always match their headers. Extra directed headers carry checksums near 0xFFFF to exercise the end-around carry.

// File: rtl/ipv4_rw_pkg.sv
package ipv4_rw_pkg;
  localparam int HDR_W      = 160;
  localparam int VER_LSB    = 156;
  localparam int IHL_LSB    = 152;
  localparam int TTL_LSB    = 88;
  localparam int CSUM_LSB   = 64;
  localparam logic [3:0] IP_VERSION = 4'd4;
  localparam logic [3:0] IHL_PLAIN  = 4'd5;
  localparam logic [7:0] TTL_MIN_FWD = 8'd2;

  typedef enum logic [1:0] {
    RSN_FWD  = 2'd0,
    RSN_MISS = 2'd1,
    RSN_TTL  = 2'd2,
    RSN_BAD  = 2'd3
  } rsn_e;
endpackage

// File: rtl/ipv4_rw_pipe_reg.sv
module ipv4_rw_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  logic         v_nxt;
  logic [W-1:0] q_nxt;

  always_comb begin
    v_nxt = q_valid;
    q_nxt = q;
    if (en) begin
      v_nxt = d_valid;
      if (d_valid) q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= v_nxt;
  end

  always_ff @(posedge clk) begin
    q <= q_nxt;
  end
endmodule

// File: rtl/ipv4_rw_classify.sv
module ipv4_rw_classify
  import ipv4_rw_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  input  logic             hit,
  output rsn_e             reason
);
  logic [3:0] ver;
  logic [3:0] ihl;
  logic [7:0] ttl;

  assign ver = hdr[VER_LSB +: 4];
  assign ihl = hdr[IHL_LSB +: 4];
  assign ttl = hdr[TTL_LSB +: 8];

  // Priority: malformed, then TTL expiry, then lookup miss (R9)
  always_comb begin
    if (ver != IP_VERSION || ihl != IHL_PLAIN) reason = RSN_BAD;
    else if (ttl < TTL_MIN_FWD)                reason = RSN_TTL;
    else if (!hit)                             reason = RSN_MISS;
    else                                       reason = RSN_FWD;
  end
endmodule

// File: rtl/ipv4_rw_ttl_csum.sv
module ipv4_rw_ttl_csum
  import ipv4_rw_pkg::*;
#(
  parameter int TTL_STEP = 1
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic [HDR_W-1:0] hdr_o
);
  localparam logic [7:0]  STEP8 = 8'(TTL_STEP);
  localparam logic [16:0] DELTA = {1'b0, STEP8, 8'h00};

  logic [15:0] csum_old;
  logic [16:0] csum_raw;
  logic [15:0] csum_new;

  assign csum_old = hdr_i[CSUM_LSB +: 16];
  assign csum_raw = {1'b0, csum_old} + DELTA;
  assign csum_new = csum_raw[15:0] + {15'd0, csum_raw[16]};

  always_comb begin
    hdr_o = hdr_i;
    hdr_o[TTL_LSB +: 8]   = hdr_i[TTL_LSB +: 8] - STEP8;
    hdr_o[CSUM_LSB +: 16] = csum_new;
  end
endmodule

// File: rtl/ipv4_fwd_rewrite.sv
module ipv4_fwd_rewrite
  import ipv4_rw_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic              in_hit,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [PORT_W-1:0] out_port,
  output logic              out_drop,
  output logic [1:0]        out_reason
);
  localparam int S1_W = HDR_W + 1 + PORT_W;
  localparam int S2_W = HDR_W + PORT_W + 2;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic              adv;
  logic              s1_v, s2_v;
  logic [S1_W-1:0]   s1_q;
  logic [S2_W-1:0]   s2_d, s2_q;
  logic [HDR_W-1:0]  s1_hdr, upd_hdr, res_hdr;
  logic              s1_hit;
  logic [PORT_W-1:0] s1_port, res_port;
  rsn_e              rsn;

  assign adv      = !s2_v || out_ready;
  assign in_ready = adv;

  ipv4_rw_pipe_reg #(.W(S1_W)) u_stage1 (
    .clk(clk), .rst_n(srst_n), .en(adv), .d_valid(in_valid),
    .d({in_hit, in_port, in_hdr}), .q_valid(s1_v), .q(s1_q)
  );

  assign {s1_hit, s1_port, s1_hdr} = s1_q;

  ipv4_rw_classify u_cls (.hdr(s1_hdr), .hit(s1_hit), .reason(rsn));

  ipv4_rw_ttl_csum #(.TTL_STEP(1)) u_upd (.hdr_i(s1_hdr), .hdr_o(upd_hdr));

  always_comb begin
    res_hdr  = s1_hdr;
    res_port = '0;
    if (rsn == RSN_FWD) begin
      res_hdr  = upd_hdr;
      res_port = s1_port;
    end
  end

  assign s2_d = {rsn, res_port, res_hdr};

  ipv4_rw_pipe_reg #(.W(S2_W)) u_stage2 (
    .clk(clk), .rst_n(srst_n), .en(adv), .d_valid(s1_v),
    .d(s2_d), .q_valid(s2_v), .q(s2_q)
  );

  assign out_valid = s2_v;
  assign {out_reason, out_port, out_hdr} = s2_q;
  assign out_drop  = (out_reason != RSN_FWD);

  // R7: stalled result holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_port) && $stable(out_reason));

  // R6: two-cycle latency when the pipeline advances
  p_latency_r6: assert property (@(posedge clk) disable iff (!srst_n)
    $past(in_valid && in_ready, 2) && $past(in_ready, 1) |-> out_valid);

  // R3: dropped results carry no port
  p_drop_port_r3: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && out_drop |-> out_port == '0);

  // R4: a forwarded header never leaves with TTL zero
  p_fwd_ttl_r4: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && out_reason == RSN_FWD |-> out_hdr[TTL_LSB +: 8] != 8'd0);

  // R1: a malformed result really has a bad version or length
  p_bad_r1: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && out_reason == RSN_BAD |->
      (out_hdr[VER_LSB +: 4] != IP_VERSION || out_hdr[IHL_LSB +: 4] != IHL_PLAIN));
endmodule

// File: tb/ipv4_fwd_rewrite_tb.sv
module ipv4_fwd_rewrite_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;
  localparam int NVEC = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid, in_ready, in_hit;
  logic [159:0]   in_hdr;
  logic [PW-1:0]  in_port;
  logic           out_valid, out_ready, out_drop;
  logic [159:0]   out_hdr;
  logic [PW-1:0]  out_port;
  logic [1:0]     out_reason;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipv4_fwd_rewrite #(.PORT_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_hit(in_hit), .in_port(in_port),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
    .out_port(out_port), .out_drop(out_drop), .out_reason(out_reason)
  );

  // vector: {version/length byte, TTL, destination, expected reason}
  localparam logic [49:0] VEC [NVEC] = '{
    {8'h45, 8'd64,  32'h0A000001, 2'd0},
    {8'h45, 8'd2,   32'h0A000002, 2'd0},
    {8'h45, 8'd1,   32'h0A000001, 2'd2},
    {8'h45, 8'd0,   32'h0A000009, 2'd2},
    {8'h45, 8'd200, 32'h0A000009, 2'd1},
    {8'h46, 8'd64,  32'h0A000001, 2'd3},
    {8'h65, 8'd1,   32'h0A000009, 2'd3},
    {8'h45, 8'd255, 32'hC0A80107, 2'd0}
  };

  localparam logic [31:0] CAM_DST  [4] = '{32'h0A000001, 32'h0A000002, 32'hC0A80107, 32'h0A000003};
  localparam logic [2:0]  CAM_PORT [4] = '{3'd2, 3'd5, 3'd7, 3'd1};

  function automatic logic [15:0] sum16(input logic [159:0] h);
    logic [31:0] s = 32'd0;
    for (int i = 0; i < 10; i++) s += {16'd0, h[i*16 +: 16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [159:0] mk(input logic [7:0] vi, input logic [7:0] ttl,
                                      input logic [31:0] dst, input logic [15:0] id);
    logic [159:0] h;
    h = {vi, 8'h00, 16'd20, id, 16'h4000, ttl, 8'h11, 16'h0000, 32'hC0A80001, dst};
    h[79:64] = ~sum16(h);
    return h;
  endfunction

  function automatic logic [15:0] csum_inc(input logic [15:0] c);
    logic [16:0] t;
    t = {1'b0, c} + 17'h00100;
    return t[15:0] + {15'd0, t[16]};
  endfunction

  task automatic cam(input logic [31:0] dst, output logic hit, output logic [2:0] port);
    hit = 1'b0; port = 3'd0;
    for (int k = 0; k < 4; k++) if (CAM_DST[k] == dst) begin hit = 1'b1; port = CAM_PORT[k]; end
  endtask

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected output for a header under the rules R1..R5, R9
  task automatic expect_out(input string tag, input logic [159:0] h, input logic hit,
                            input logic [2:0] port, input logic [1:0] rsn);
    logic [159:0] e;
    e = h;
    if (rsn == 2'd0) begin
      e[95:88] = h[95:88] - 8'd1;
      e[79:64] = csum_inc(h[79:64]);
    end
    check({tag, " reason"}, {158'd0, out_reason}, {158'd0, rsn});
    check({tag, " drop"}, {159'd0, out_drop}, {159'd0, rsn != 2'd0});
    check({tag, " hdr"}, out_hdr, e);
    check({tag, " port"}, {157'd0, out_port}, {157'd0, (rsn == 2'd0) ? port : 3'd0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [159:0] h, ha, hb;
    logic         hit;
    logic [2:0]   port;
    string        tag;

    rst_n = 1'b0; in_valid = 1'b0; in_hdr = '0; in_hit = 1'b0; in_port = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check("R8 out_valid", {159'd0, out_valid}, 160'd0);
    check("R8 in_ready", {159'd0, in_ready}, 160'd1);

    // vector table: R1 R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      h = mk(VEC[v][49:42], VEC[v][41:34], VEC[v][33:2], 16'(v + 16'h100));
      cam(VEC[v][33:2], hit, port);
      in_hdr = h; in_hit = hit; in_port = port; in_valid = 1'b1;
      check($sformatf("R6 in_ready v%0d", v), {159'd0, in_ready}, 160'd1);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R6 one cycle v%0d", v), {159'd0, out_valid}, 160'd0);
      @(negedge clk);
      check($sformatf("R6 two cycles v%0d", v), {159'd0, out_valid}, 160'd1);
      case (VEC[v][1:0])
        2'd0: tag = "R4";
        2'd1: tag = "R3";
        2'd2: tag = "R2";
        default: tag = "R1";
      endcase
      expect_out($sformatf("%s/R9 v%0d", tag, v), h, hit, port, VEC[v][1:0]);
      if (VEC[v][1:0] == 2'd0)
        check($sformatf("R5 sum v%0d", v), {144'd0, sum16(out_hdr)}, {144'd0, 16'hFFFF});
      @(negedge clk);
    end

    // R5: end-around carry cases
    for (int c = 0; c < 2; c++) begin
      h = mk(8'h45, 8'd30, 32'h0A000001, 16'h0777);
      h[79:64] = (c == 0) ? 16'hFF80 : 16'hFF00;
      in_hdr = h; in_hit = 1'b1; in_port = 3'd2; in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R5 wrap csum", {144'd0, out_hdr[79:64]}, {144'd0, (c == 0) ? 16'h0081 : 16'h0001});
      check("R5 wrap ttl", {152'd0, out_hdr[95:88]}, {152'd0, 8'd29});
      @(negedge clk);
    end

    // R7: back-pressure holds A, then delivers B with no loss
    ha = mk(8'h45, 8'd9, 32'h0A000002, 16'h0AAA);
    hb = mk(8'h45, 8'd3, 32'h0A000009, 16'h0BBB);
    out_ready = 1'b0;
    in_hdr = ha; in_hit = 1'b1; in_port = 3'd5; in_valid = 1'b1;
    @(negedge clk);
    in_hdr = hb; in_hit = 1'b0; in_port = 3'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 stall valid", {159'd0, out_valid}, 160'd1);
    check("R7 stall in_ready", {159'd0, in_ready}, 160'd0);
    repeat (3) @(negedge clk);
    check("R7 still stalled", {159'd0, in_ready}, 160'd0);
    expect_out("R7 held A", ha, 1'b1, 3'd5, 2'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 B valid", {159'd0, out_valid}, 160'd1);
    expect_out("R7 B", hb, 1'b0, 3'd0, 2'd1);
    @(negedge clk);
    check("R7 drained", {159'd0, out_valid}, 160'd0);

    // R8: reset mid-stream clears the output
    in_hdr = ha; in_hit = 1'b1; in_port = 3'd5; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears", {159'd0, out_valid}, 160'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after reset", {159'd0, out_valid}, 160'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule